// File: doc/BRIEF.md
# Outbound Audio Link Frame Deframer

This block sits on the codec side of a High Definition Audio link and takes apart the outbound frames that arrive on one serial data line. The data line is sampled on both edges of the bit clock, so each clock period carries two data bits. The frame marker and the stream tags arrive one bit per period on SYNC. The block finds each 48 kHz frame from the SYNC marker and delivers the 32-bit command word that opens the frame. It reads every stream tag on SYNC. It keeps only the stream whose ID matches a configured value and delivers that stream's samples as parallel words. Each sample comes with a valid strobe and a flag on the first sample of every block.

A stream's extent comes only from SYNC timing: its data starts in the period after its tag ends, and it ends when the next tag completes or a new frame starts. For the selected stream, a configured number of blocks per frame also ends the capture, so bits in the null field at the end of a frame are never taken as samples. A frame-length counter compares each frame with the expected 500 bit clocks.

Top module: `hda_out_deframer`

## Requirements
- R1: After reset, cmd_valid, smp_valid and frame_err are low. No command word or sample is delivered until a frame marker has been seen, even if valid-looking tags and data arrive before it.
- R2: In each bit-clock period the SDO bit sampled at the rising edge comes before the bit sampled at the following falling edge in the serial order of the frame.
- R3: A frame marker is SYNC high for four consecutive periods followed by a low period. That low period is period 0 of the new frame and carries command bits 31 and 30.
- R4: The 32 command bits in periods 0 to 15 are assembled most significant first and delivered on cmd_word with cmd_valid high for one cycle, once per frame.
- R5: Outside a marker or another tag, a tag starts in the first period with SYNC high and spans eight SYNC samples: a 4-bit preamble, then a 4-bit stream ID, both most significant first. cfg_preamble must have bit 3 set and must not be 4'b1111. A tag whose preamble does not equal cfg_preamble is ignored.
- R6: The data of a stream whose ID equals cfg_stream_id begins in the period after its tag's last bit. Samples are taken most significant bit first, 20 bits wide when cfg_wide is 1 and 16 bits otherwise, and are right-aligned and zero-extended on smp_data.
- R7: smp_first is high with the first sample of each block, a block being cfg_chans consecutive samples.
- R8: The selected stream yields at most cfg_blocks*cfg_chans samples per frame. Any later bits in the frame produce no sample.
- R9: Data of a stream whose ID does not match produces no sample. Capture of the selected stream ends when another tag completes or a frame starts. The data bits of the period in which that tag completes still count, and a sample left incomplete is dropped.
- R10: Once locked, frame_err pulses for one cycle at a frame start if the frame just ended did not last FRAME_CLKS (500) periods. The first frame start after reset is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker and stream tag line |
| sdo | input | 1 | Outbound serial data, two bits per clock period |
| cfg_preamble | input | 4 | Expected tag preamble |
| cfg_stream_id | input | 4 | Stream ID to extract |
| cfg_wide | input | 1 | 1 = 20-bit samples, 0 = 16-bit samples |
| cfg_chans | input | 3 | Samples per block (1 to CH_MAX) |
| cfg_blocks | input | 3 | Blocks per frame for the selected stream (1 to BLK_MAX) |
| cmd_valid | output | 1 | One-cycle strobe for a new command word |
| cmd_word | output | 32 | Captured command word |
| smp_valid | output | 1 | Sample strobe |
| smp_first | output | 1 | Sample is the first of its block |
| smp_data | output | 20 | Sample value, right-aligned |
| frame_err | output | 1 | One-cycle frame-length mismatch pulse |

## Verification
The bench places the selected stream's tag over the last periods of a preceding foreign stream. A deframer that lets the new tag cut off the old stream's last data pair, or that starts capture one period early or late, delivers shifted or missing samples. It fills the null field with ones: a design that ignores the block limit emits extra samples. A tag with a wrong preamble whose ID matches must produce nothing. A selected stream cut by a foreign tag in the middle of a sample must yield only the completed sample. Swapping the two edges or misplacing period 0 of a frame corrupts every command word, and a frame one period short must raise exactly one error pulse.

// File: rtl/hda_deframer_pkg.sv
package hda_deframer_pkg;
  localparam int CMD_BITS   = 32;
  localparam int CMD_CLKS   = CMD_BITS / 2;
  localparam int SMP_W_MAX  = 20;
  localparam int SMP_W_NARROW = 16;
  localparam logic [3:0] MARK_NIB = 4'hF;

  typedef enum logic [3:0] {
    SC_IDLE = 4'd0,
    SC_PRE3 = 4'd3,
    SC_ID0  = 4'd4,
    SC_ID3  = 4'd7,
    SC_MARK = 4'd15
  } sync_cnt_e;
endpackage

// File: rtl/hda_edge_capture.sv
module hda_edge_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync,
  input  logic       sdo,
  output logic       sync_o,
  output logic [1:0] pair_o
);
  logic fall_q;
  logic rise_q;
  logic sync_q;

  // falling-edge sample of the data line
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= sdo;
  end

  // rising-edge samples, then realign both bits of one period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      sync_q <= 1'b0;
      sync_o <= 1'b0;
      pair_o <= 2'b00;
    end else begin
      rise_q <= sdo;
      sync_q <= sync;
      sync_o <= sync_q;
      pair_o <= {rise_q, fall_q};
    end
  end
endmodule

// File: rtl/hda_sync_tracker.sv
module hda_sync_tracker
  import hda_deframer_pkg::*;
#(
  parameter int FRAME_CLKS = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_b,
  input  logic [1:0]  pair,
  input  logic [3:0]  cfg_preamble,
  output logic        frame_start,
  output logic        tag_done,
  output logic [3:0]  tag_id,
  output logic        locked,
  output logic        cmd_valid,
  output logic [31:0] cmd_word,
  output logic        frame_err
);
  localparam int PW = $clog2(FRAME_CLKS + 1) + 1;
  localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

  logic [3:0]    scnt_q, scnt_d;
  logic [6:0]    sbits_q;
  logic [7:0]    bits_n;
  logic [PW-1:0] pos_q, pos_d, cur_pos;
  logic          locked_d;
  logic [29:0]   csr_q, csr_d;
  logic          cval_d;
  logic [31:0]   cword_d;
  logic          err_d;
  logic          in_cmd;

  always_comb begin
    bits_n      = {sbits_q, sync_b};
    frame_start = (scnt_q == SC_MARK) && !sync_b;
    tag_done    = (scnt_q == SC_ID3);
    tag_id      = bits_n[3:0];
    unique case (scnt_q)
      SC_MARK: scnt_d = sync_b ? SC_MARK : SC_IDLE;
      SC_IDLE: scnt_d = sync_b ? 4'd1 : SC_IDLE;
      SC_PRE3: begin
        if (bits_n[3:0] == MARK_NIB)          scnt_d = SC_MARK;
        else if (bits_n[3:0] == cfg_preamble) scnt_d = SC_ID0;
        else                                  scnt_d = SC_IDLE;
      end
      SC_ID3:  scnt_d = SC_IDLE;
      default: scnt_d = scnt_q + 4'd1;
    endcase

    cur_pos  = frame_start ? '0 : pos_q;
    pos_d    = (cur_pos == POS_MAX) ? cur_pos : cur_pos + 1'b1;
    locked_d = locked | frame_start;
    in_cmd   = locked_d && (cur_pos < PW'(CMD_CLKS));
    csr_d    = in_cmd ? {csr_q[27:0], pair} : csr_q;
    cval_d   = in_cmd && (cur_pos == PW'(CMD_CLKS - 1));
    cword_d  = cval_d ? {csr_q, pair} : cmd_word;
    err_d    = frame_start && locked && (pos_q != PW'(FRAME_CLKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q    <= SC_IDLE;
      sbits_q   <= '0;
      pos_q     <= '0;
      locked    <= 1'b0;
      csr_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      frame_err <= 1'b0;
    end else begin
      scnt_q    <= scnt_d;
      sbits_q   <= bits_n[6:0];
      pos_q     <= pos_d;
      locked    <= locked_d;
      csr_q     <= csr_d;
      cmd_valid <= cval_d;
      cmd_word  <= cword_d;
      frame_err <= err_d;
    end
  end

  assert_cmd_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_err_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(frame_start));
  assert_tag_not_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && tag_done));
  assert_cmd_needs_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> locked);
endmodule

// File: rtl/hda_stream_extract.sv
module hda_stream_extract
  import hda_deframer_pkg::*;
#(
  parameter int CH_MAX  = 4,
  parameter int BLK_MAX = 4,
  localparam int CW = $clog2(CH_MAX + 1),
  localparam int BW = $clog2(BLK_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pair,
  input  logic                 frame_start,
  input  logic                 tag_done,
  input  logic [3:0]           tag_id,
  input  logic                 locked,
  input  logic [3:0]           cfg_stream_id,
  input  logic                 cfg_wide,
  input  logic [CW-1:0]        cfg_chans,
  input  logic [BW-1:0]        cfg_blocks,
  output logic                 smp_valid,
  output logic                 smp_first,
  output logic [SMP_W_MAX-1:0] smp_data
);
  localparam int TW = $clog2(CH_MAX * BLK_MAX + 1);

  logic                 on_q, on_d;
  logic [SMP_W_MAX-3:0] sr_q, sr_d;
  logic [4:0]           bit_q, bit_d, bit_n;
  logic [CW-1:0]        ch_q, ch_d;
  logic [TW-1:0]        tot_q, tot_d, tot_n, limit;
  logic [4:0]           width;
  logic [SMP_W_MAX-1:0] word, data_d;
  logic                 v_d, first_d;

  always_comb begin
    width   = cfg_wide ? 5'(SMP_W_MAX) : 5'(SMP_W_NARROW);
    limit   = TW'(cfg_chans) * TW'(cfg_blocks);
    word    = {sr_q, pair};
    bit_n   = bit_q + 5'd2;
    tot_n   = tot_q + 1'b1;
    on_d    = on_q;
    sr_d    = sr_q;
    bit_d   = bit_q;
    ch_d    = ch_q;
    tot_d   = tot_q;
    v_d     = 1'b0;
    first_d = 1'b0;
    data_d  = smp_data;
    // data of this period is consumed before any tag ending here
    if (on_q && !frame_start) begin
      sr_d  = word[SMP_W_MAX-3:0];
      bit_d = bit_n;
      if (bit_n == width) begin
        v_d     = 1'b1;
        first_d = (ch_q == '0);
        data_d  = cfg_wide ? word
                           : {{(SMP_W_MAX-SMP_W_NARROW){1'b0}}, word[SMP_W_NARROW-1:0]};
        bit_d   = '0;
        ch_d    = (ch_q == cfg_chans - 1'b1) ? '0 : ch_q + 1'b1;
        tot_d   = tot_n;
        if (tot_n == limit) on_d = 1'b0;
      end
    end
    if (frame_start) begin
      on_d = 1'b0;
    end else if (tag_done && locked) begin
      on_d  = (tag_id == cfg_stream_id);
      bit_d = '0;
      ch_d  = '0;
      tot_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q      <= 1'b0;
      sr_q      <= '0;
      bit_q     <= '0;
      ch_q      <= '0;
      tot_q     <= '0;
      smp_valid <= 1'b0;
      smp_first <= 1'b0;
      smp_data  <= '0;
    end else begin
      on_q      <= on_d;
      sr_q      <= sr_d;
      bit_q     <= bit_d;
      ch_q      <= ch_d;
      tot_q     <= tot_d;
      smp_valid <= v_d;
      smp_first <= first_d;
      smp_data  <= data_d;
    end
  end

  assert_first_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_first |-> smp_valid);
  assert_block_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (tot_q < limit));
  assert_quiet_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !smp_valid);
  assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !cfg_wide) |-> (smp_data[SMP_W_MAX-1:SMP_W_NARROW] == '0));
endmodule

// File: rtl/hda_out_deframer.sv
module hda_out_deframer
  import hda_deframer_pkg::*;
#(
  parameter int FRAME_CLKS = 500,
  parameter int CH_MAX     = 4,
  parameter int BLK_MAX    = 4,
  parameter int RST_STAGES = 2,
  localparam int CW = $clog2(CH_MAX + 1),
  localparam int BW = $clog2(BLK_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic                 sdo,
  input  logic [3:0]           cfg_preamble,
  input  logic [3:0]           cfg_stream_id,
  input  logic                 cfg_wide,
  input  logic [CW-1:0]        cfg_chans,
  input  logic [BW-1:0]        cfg_blocks,
  output logic                 cmd_valid,
  output logic [31:0]          cmd_word,
  output logic                 smp_valid,
  output logic                 smp_first,
  output logic [SMP_W_MAX-1:0] smp_data,
  output logic                 frame_err
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;
  logic                  sync_b;
  logic [1:0]            pair;
  logic                  frame_start, tag_done, locked;
  logic [3:0]            tag_id;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  hda_edge_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sync   (sync),
    .sdo    (sdo),
    .sync_o (sync_b),
    .pair_o (pair)
  );

  hda_sync_tracker #(.FRAME_CLKS(FRAME_CLKS)) u_trk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .sync_b       (sync_b),
    .pair         (pair),
    .cfg_preamble (cfg_preamble),
    .frame_start  (frame_start),
    .tag_done     (tag_done),
    .tag_id       (tag_id),
    .locked       (locked),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .frame_err    (frame_err)
  );

  hda_stream_extract #(.CH_MAX(CH_MAX), .BLK_MAX(BLK_MAX)) u_ext (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .pair          (pair),
    .frame_start   (frame_start),
    .tag_done      (tag_done),
    .tag_id        (tag_id),
    .locked        (locked),
    .cfg_stream_id (cfg_stream_id),
    .cfg_wide      (cfg_wide),
    .cfg_chans     (cfg_chans),
    .cfg_blocks    (cfg_blocks),
    .smp_valid     (smp_valid),
    .smp_first     (smp_first),
    .smp_data      (smp_data)
  );
endmodule

// File: tb/hda_out_deframer_bench.sv
module hda_out_deframer_bench;
  localparam logic [3:0] PRE = 4'b1010;
  // {id[3:0], wide, chans[2:0], 1'b0, blocks[2:0]}
  localparam logic [11:0] VEC [0:5] = '{12'h521, 12'h6A2, 12'h014, 12'hFC1, 12'h944, 12'h3B2};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync, sdo;
  logic [3:0]  cfg_preamble, cfg_stream_id;
  logic        cfg_wide;
  logic [2:0]  cfg_chans, cfg_blocks;
  logic        cmd_valid, smp_valid, smp_first, frame_err;
  logic [31:0] cmd_word;
  logic [19:0] smp_data;

  always #2 clk = ~clk;

  hda_out_deframer u_hda_out_deframer (
    .clk(clk), .rst_n(rst_n), .sync(sync), .sdo(sdo),
    .cfg_preamble(cfg_preamble), .cfg_stream_id(cfg_stream_id),
    .cfg_wide(cfg_wide), .cfg_chans(cfg_chans), .cfg_blocks(cfg_blocks),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .smp_valid(smp_valid),
    .smp_first(smp_first), .smp_data(smp_data), .frame_err(frame_err)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic fs [0:511];
  logic fr [0:511];
  logic ff [0:511];

  logic [19:0] exp_d [0:511];
  logic        exp_f [0:511];
  logic [31:0] exp_c [0:15];
  int n_exp, n_expc;

  logic [19:0] obs_d [0:511];
  logic        obs_f [0:511];
  logic [31:0] obs_c [0:15];
  int n_obs, n_obsc, n_err;

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid && n_obs < 512) begin
        obs_d[n_obs] = smp_data; obs_f[n_obs] = smp_first; n_obs++;
      end
      if (cmd_valid && n_obsc < 16) begin
        obs_c[n_obsc] = cmd_word; n_obsc++;
      end
      if (frame_err) n_err++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic f);
    @(negedge clk); #1; sync = s; sdo = r;
    @(posedge clk); #1; sdo = f;
  endtask

  task automatic do_reset();
    sync = 1'b0; sdo = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_exp = 0; n_expc = 0; n_obs = 0; n_obsc = 0; n_err = 0;
  endtask

  task automatic clear_frame(input int len);
    for (int c = 0; c < 512; c++) begin fs[c] = 1'b0; fr[c] = 1'b0; ff[c] = 1'b0; end
    for (int c = len - 4; c < len; c++) fs[c] = 1'b1;
  endtask

  task automatic put_bit(input int bp, input logic b);
    if (bp % 2 == 0) fr[bp/2] = b; else ff[bp/2] = b;
  endtask

  task automatic put_cmd(input logic [31:0] w);
    for (int i = 0; i < 32; i++) put_bit(i, w[31-i]);
  endtask

  task automatic put_tag(input int start, input logic [3:0] pre, input logic [3:0] id);
    for (int i = 0; i < 8; i++) fs[start+i] = ({pre, id} >> (7 - i)) & 1'b1;
  endtask

  task automatic put_sample(inout int bp, input logic [19:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin put_bit(bp, v[i]); bp++; end
  endtask

  task automatic send_frame(input int len);
    for (int c = 0; c < len; c++) drive(fs[c], fr[c], ff[c]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic lead_marker();
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0);
  endtask

  function automatic logic [19:0] gen(input int vi, input int f, input int k, input bit wide);
    logic [19:0] v;
    v = 20'(((k + 1) * 20'h1B3A7) ^ (f * 20'h3F001) ^ (vi * 20'h00A5C));
    return wide ? v : {4'h0, v[15:0]};
  endfunction

  // foreign stream then selected stream overlapping its tail, null field of ones
  task automatic build_std(input int vi, input int f, input int len);
    int bp;
    logic [31:0] cw;
    int w;
    w  = cfg_wide ? 20 : 16;
    cw = 32'hC0DE_0000 ^ (32'(vi) << 8) ^ 32'(f) ^ 32'h8000_0001;
    clear_frame(len);
    put_cmd(cw);
    exp_c[n_expc] = cw; n_expc++;
    put_tag(8, PRE, cfg_stream_id ^ 4'h8);
    for (int c = 16; c < 56; c++) begin fr[c] = 1'b1; ff[c] = 1'b0; end
    put_tag(48, PRE, cfg_stream_id);
    bp = 112;
    for (int k = 0; k < int'(cfg_blocks) * int'(cfg_chans); k++) begin
      exp_d[n_exp] = gen(vi, f, k, cfg_wide);
      exp_f[n_exp] = (k % int'(cfg_chans)) == 0;
      n_exp++;
      put_sample(bp, gen(vi, f, k, cfg_wide), w);
    end
    for (int b = bp; b < (len - 4) * 2; b++) put_bit(b, 1'b1);
  endtask

  task automatic compare_all(input string tag);
    check(n_obsc == n_expc, {"R4 command count ", tag}, 32'(n_obsc), 32'(n_expc));
    for (int i = 0; i < n_expc && i < n_obsc; i++)
      check(obs_c[i] === exp_c[i], {"R2 R3 R4 command word ", tag}, obs_c[i], exp_c[i]);
    check(n_obs == n_exp, {"R8 R9 sample count ", tag}, 32'(n_obs), 32'(n_exp));
    for (int i = 0; i < n_exp && i < n_obs; i++) begin
      check(obs_d[i] === exp_d[i], {"R6 sample value ", tag}, 32'(obs_d[i]), 32'(exp_d[i]));
      check(obs_f[i] === exp_f[i], {"R7 block first flag ", tag}, 32'(obs_f[i]), 32'(exp_f[i]));
    end
  endtask

  initial begin
    cfg_preamble = PRE;
    cfg_stream_id = 4'h5; cfg_wide = 1'b0; cfg_chans = 3'd2; cfg_blocks = 3'd1;
    sync = 1'b0; sdo = 1'b0; rst_n = 1'b0;
    #1;
    repeat (2) @(negedge clk);
    check(!cmd_valid && !smp_valid && !frame_err, "R1 outputs in reset", 32'({cmd_valid, smp_valid, frame_err}), 32'h0);

    // R1: traffic before any marker is not delivered
    do_reset();
    check(!cmd_valid && !smp_valid && !frame_err, "R1 outputs after reset", 32'({cmd_valid, smp_valid, frame_err}), 32'h0);
    build_std(7, 0, 500);
    n_expc = 0; n_exp = 0;
    send_frame(500);
    idle(20);
    check(n_obs == 0, "R1 no sample before lock", 32'(n_obs), 32'h0);
    check(n_obsc == 1 && obs_c[0] == 32'h0, "R1 R3 first command after marker", 32'(n_obsc), 32'h1);

    // table of configurations
    for (int vi = 0; vi < 6; vi++) begin
      cfg_stream_id = VEC[vi][11:8];
      cfg_wide      = VEC[vi][7];
      cfg_chans     = VEC[vi][6:4];
      cfg_blocks    = VEC[vi][2:0];
      do_reset();
      lead_marker();
      for (int f = 0; f < 2; f++) begin build_std(vi, f, 500); send_frame(500); end
      idle(4);
      compare_all($sformatf("vec%0d", vi));
      check(n_err == 0, "R10 no error on correct frames", 32'(n_err), 32'h0);
    end

    // R10: one frame a period short
    cfg_stream_id = 4'h5; cfg_wide = 1'b0; cfg_chans = 3'd2; cfg_blocks = 3'd1;
    do_reset();
    lead_marker();
    build_std(10, 0, 500); send_frame(500);
    build_std(10, 1, 499); send_frame(499);
    build_std(10, 2, 500); send_frame(500);
    idle(4);
    check(n_err == 1, "R10 short frame flagged once", 32'(n_err), 32'h1);
    compare_all("short");

    // R5: wrong preamble with matching ID is ignored
    cfg_stream_id = 4'h3; cfg_wide = 1'b0; cfg_chans = 3'd1; cfg_blocks = 3'd1;
    do_reset();
    lead_marker();
    clear_frame(500);
    put_cmd(32'h1234_5678);
    put_tag(8, 4'b1100, 4'h3);
    begin int bp; bp = 32; put_sample(bp, 20'h0ABCD, 16); end
    send_frame(500);
    idle(4);
    check(n_obs == 0, "R5 bad preamble ignored", 32'(n_obs), 32'h0);
    check(n_obsc == 1 && obs_c[0] == 32'h1234_5678, "R4 command with bad tag", obs_c[0], 32'h1234_5678);

    // R9: selected stream cut by a foreign tag mid-sample
    cfg_stream_id = 4'h2; cfg_wide = 1'b0; cfg_chans = 3'd4; cfg_blocks = 3'd1;
    do_reset();
    lead_marker();
    clear_frame(500);
    put_cmd(32'hFEED_0002);
    put_tag(8, PRE, 4'h2);
    begin int bp; bp = 32; put_sample(bp, 20'h0C3A5, 16); put_sample(bp, 20'h0FFFF, 16); end
    put_tag(18, PRE, 4'h7);
    send_frame(500);
    idle(4);
    check(n_obs == 1, "R9 partial sample dropped", 32'(n_obs), 32'h1);
    check(n_obs > 0 && obs_d[0] == 20'h0C3A5 && obs_f[0], "R9 R7 completed sample kept", 32'(obs_d[0]), 32'h0C3A5);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule